// File: doc/BRIEF.md
# Byte-Wide NOR Flash Bank Programmer

This sequencer drives a byte-wide NOR flash over a plain parallel bus. The device is told what to do with command cycles that follow a two-write unlock pattern. A single start pulse, together with an operation select and a bank index, runs one complete job. The job is either a sector erase of the selected bank or a byte-by-byte program of the whole bank from an external source buffer. For a program job, the sequencer presents a byte index to the buffer and takes the returned byte on the same cycle.

The sequencer does not read a status register to learn when the flash has finished. It reads the bank base twice in a row and compares the two values. While an internal operation is in progress the device toggles a bit on every read, so two equal values mean the operation has completed. Polling stops after a configurable number of unequal pairs and raises a timeout.

Every job ends with a reset command to the bank base. A verify pass then reads the bank back. After an erase every byte must read as erased (0xFF). After a program every byte must equal the source buffer. At the end the sequencer pulses done, and the timeout and verify-error flags hold their values until the next job starts.

Top module: `flash_bank_prog`

## Requirements
- R1: An erase job issues, in this order: 0xAA to offset UNLOCK_A, 0x55 to offset UNLOCK_B, 0x80 to UNLOCK_A, 0xAA to UNLOCK_A, 0x55 to UNLOCK_B, then 0x30 to offset 0. UNLOCK_A defaults to 0x555 and UNLOCK_B to 0x2AA.
- R2: A program job handles the bytes in ascending index order. For each byte it writes 0xAA to UNLOCK_A, 0x55 to UNLOCK_B and 0xA0 to UNLOCK_A, then writes the source byte for that index to offset index. The next byte starts only after polling for the current one completes.
- R3: Every bus address is the bank index times BANK_BYTES plus the offset; the bank index sits in the upper address bits. No access of a job falls outside the selected bank.
- R4: After each write strobe, at least GAP_CYCLES cycles pass with neither strobe asserted.
- R5: Each poll attempt is a pair of back-to-back reads of offset 0. Read data is taken on the cycle after each read strobe. A pair with equal values (XOR zero) completes the poll.
- R6: After POLL_LIMIT unequal pairs in one poll, the timeout flag is set and the job stops issuing program or erase commands. In that case exactly 2×POLL_LIMIT reads occur between the last command write and the reset write.
- R7: Every job, whether it completed or timed out, issues the reset command 0xF0 to offset 0 after its command writes.
- R8: After the reset write, a verify pass reads the bank from offset 0 upward. An erase expects 0xFF and a program expects the source byte. The first mismatch sets the verify-error flag and ends the job.
- R9: Busy is high from the cycle after an accepted start until done. Done is a one-cycle pulse. The timeout and verify-error flags stay unchanged from done until the next accepted start, which clears them.
- R10: A start pulse while busy is ignored; the running job's bus sequence is unchanged.
- R11: The write strobe and read strobe are never high in the same cycle.
- R12: Out of reset, busy, done, both flags and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| op_prog | input | 1 | 1 = program the bank, 0 = erase it |
| bank | input | BANK_W | Bank index |
| src_idx | output | log2(BANK_BYTES) | Byte index presented to the source buffer |
| src_data | input | 8 | Source byte for src_idx, same cycle |
| fl_addr | output | BANK_W+log2(BANK_BYTES) | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | One-cycle write strobe |
| fl_re | output | 1 | One-cycle read strobe |
| fl_rdata | input | 8 | Read data, valid the cycle after fl_re |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| timeout | output | 1 | Poll limit was reached during the last job |
| verify_err | output | 1 | Verify found a mismatch during the last job |

## Verification
A bench flash model applies the unlock grammar, erases a bank, clears bits on program, and toggles a read bit while it is busy. Jobs run against this model as follows:
- Erase of a bank filled with arbitrary data, and programs of two distinct patterns into each bank. Together these separate correct command order and bank placement from swapped offsets or a wrong base.
- A program over an unerased bank. Here the bit-clearing model leaves bytes that cannot match, so it shows whether verify really compares against the source.
- A device held permanently busy, for both job types. This tells a poll that counts its pairs exactly from one that stops early or never stops, and it shows that programming halts after the first byte.
- A start pulse injected in the middle of a job, which must leave the write sequence untouched.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  localparam logic [7:0] CMD_UNLK1     = 8'hAA;
  localparam logic [7:0] CMD_UNLK2     = 8'h55;
  localparam logic [7:0] CMD_ERASE_ARM = 8'h80;
  localparam logic [7:0] CMD_SECTOR    = 8'h30;
  localparam logic [7:0] CMD_PROG      = 8'hA0;
  localparam logic [7:0] CMD_RESET     = 8'hF0;
  localparam logic [7:0] ERASED_BYTE   = 8'hFF;

  typedef enum logic [1:0] {SEL_UNLK_A, SEL_UNLK_B, SEL_BASE, SEL_TARGET} off_sel_e;

  typedef struct packed {
    off_sel_e    sel;
    logic [7:0]  data;
  } cmd_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD_W, ST_CMD_GAP, ST_POLL_R1, ST_POLL_R2, ST_POLL_C,
    ST_RST_W, ST_RST_GAP, ST_VER_RD, ST_VER_CMP, ST_FIN
  } fbp_state_e;

  // index of the final command write of a sequence
  function automatic logic [2:0] seq_last(input logic is_prog);
    return is_prog ? 3'd3 : 3'd5;
  endfunction

  // command word for a given step of the erase or program sequence
  function automatic cmd_t seq_step(input logic is_prog, input logic [2:0] step);
    cmd_t c;
    c = '{sel: SEL_BASE, data: 8'h00};
    if (is_prog) begin
      case (step)
        3'd0:    c = '{sel: SEL_UNLK_A, data: CMD_UNLK1};
        3'd1:    c = '{sel: SEL_UNLK_B, data: CMD_UNLK2};
        3'd2:    c = '{sel: SEL_UNLK_A, data: CMD_PROG};
        default: c = '{sel: SEL_TARGET, data: 8'h00};
      endcase
    end else begin
      case (step)
        3'd0:    c = '{sel: SEL_UNLK_A, data: CMD_UNLK1};
        3'd1:    c = '{sel: SEL_UNLK_B, data: CMD_UNLK2};
        3'd2:    c = '{sel: SEL_UNLK_A, data: CMD_ERASE_ARM};
        3'd3:    c = '{sel: SEL_UNLK_A, data: CMD_UNLK1};
        3'd4:    c = '{sel: SEL_UNLK_B, data: CMD_UNLK2};
        default: c = '{sel: SEL_BASE,   data: CMD_SECTOR};
      endcase
    end
    return c;
  endfunction

  // toggle-bit test: two reads agree when the device is idle
  function automatic logic poll_settled(input logic [7:0] a, input logic [7:0] b);
    return (a ^ b) == 8'h00;
  endfunction

endpackage

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
  parameter int GAP_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(GAP_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= CW'(GAP_CYCLES);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == CW'(1));

  a_r4_gap_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) && !load |=> (cnt == '0));

endmodule

// File: rtl/flash_poll_ctr.sv
module flash_poll_ctr #(
  parameter int POLL_LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic miss,
  output logic limit_hit
);
  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt;

  assign limit_hit = miss && (cnt == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (clear)              cnt <= '0;
    else if (miss && !limit_hit) cnt <= cnt + CW'(1);
  end

  a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(POLL_LIMIT));

endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
  import flash_prog_pkg::*;
#(
  parameter int BANK_W     = 1,
  parameter int BANK_BYTES = 8192,
  parameter int UNLOCK_A   = 'h555,
  parameter int UNLOCK_B   = 'h2AA,
  parameter int GAP_CYCLES = 16,
  parameter int POLL_LIMIT = 1000000,
  localparam int OFF_W     = $clog2(BANK_BYTES),
  localparam int ADDR_W    = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_prog,
  input  logic [BANK_W-1:0] bank,
  output logic [OFF_W-1:0]  src_idx,
  input  logic [7:0]        src_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              verify_err
);

  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(BANK_BYTES - 1);
  localparam logic [OFF_W-1:0] OFF_A    = OFF_W'(UNLOCK_A);
  localparam logic [OFF_W-1:0] OFF_B    = OFF_W'(UNLOCK_B);

  fbp_state_e        state;
  logic              op_q;
  logic [BANK_W-1:0] bank_q;
  logic [OFF_W-1:0]  idx;
  logic [2:0]        step;
  logic [7:0]        rd_first;
  logic              timeout_q, verr_q;

  // named internal events
  logic  gap_done, poll_clear, poll_miss, poll_limit, pair_equal, ver_mismatch;
  cmd_t  cur_cmd;
  logic [OFF_W-1:0] off;
  logic [7:0]       ver_expect;

  assign cur_cmd      = seq_step(op_q, step);
  assign pair_equal   = poll_settled(rd_first, fl_rdata);
  assign poll_clear   = (state == ST_CMD_GAP);
  assign poll_miss    = (state == ST_POLL_C) && !pair_equal;
  assign ver_expect   = op_q ? src_data : ERASED_BYTE;
  assign ver_mismatch = (state == ST_VER_CMP) && (fl_rdata != ver_expect);

  flash_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) i_gap (
    .clk(clk), .rst_n(rst_n), .load(fl_we), .expired(gap_done));

  flash_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) i_poll (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear), .miss(poll_miss),
    .limit_hit(poll_limit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= 1'b0;
      bank_q    <= '0;
      idx       <= '0;
      step      <= '0;
      rd_first  <= '0;
      timeout_q <= 1'b0;
      verr_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          op_q      <= op_prog;
          bank_q    <= bank;
          idx       <= '0;
          step      <= '0;
          timeout_q <= 1'b0;
          verr_q    <= 1'b0;
          state     <= ST_CMD_W;
        end
        ST_CMD_W:   state <= ST_CMD_GAP;
        ST_CMD_GAP: if (gap_done) begin
          if (step == seq_last(op_q)) begin
            step  <= '0;
            state <= ST_POLL_R1;
          end else begin
            step  <= step + 3'd1;
            state <= ST_CMD_W;
          end
        end
        ST_POLL_R1: state <= ST_POLL_R2;
        ST_POLL_R2: begin
          rd_first <= fl_rdata;
          state    <= ST_POLL_C;
        end
        ST_POLL_C: begin
          if (pair_equal) begin
            if (op_q && idx != LAST_IDX) begin
              idx   <= idx + OFF_W'(1);
              state <= ST_CMD_W;
            end else begin
              state <= ST_RST_W;
            end
          end else if (poll_limit) begin
            timeout_q <= 1'b1;
            state     <= ST_RST_W;
          end else begin
            state <= ST_POLL_R1;
          end
        end
        ST_RST_W:   state <= ST_RST_GAP;
        ST_RST_GAP: if (gap_done) begin
          idx   <= '0;
          state <= ST_VER_RD;
        end
        ST_VER_RD:  state <= ST_VER_CMP;
        ST_VER_CMP: begin
          if (ver_mismatch) begin
            verr_q <= 1'b1;
            state  <= ST_FIN;
          end else if (idx == LAST_IDX) begin
            state  <= ST_FIN;
          end else begin
            idx    <= idx + OFF_W'(1);
            state  <= ST_VER_RD;
          end
        end
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    off      = '0;
    fl_wdata = 8'h00;
    case (state)
      ST_CMD_W: begin
        case (cur_cmd.sel)
          SEL_UNLK_A: off = OFF_A;
          SEL_UNLK_B: off = OFF_B;
          SEL_TARGET: off = idx;
          default:    off = '0;
        endcase
        fl_wdata = (cur_cmd.sel == SEL_TARGET) ? src_data : cur_cmd.data;
      end
      ST_RST_W:  fl_wdata = CMD_RESET;
      ST_VER_RD: off = idx;
      default: ;
    endcase
  end

  assign fl_addr    = {bank_q, off};
  assign fl_we      = (state == ST_CMD_W) || (state == ST_RST_W);
  assign fl_re      = (state == ST_POLL_R1) || (state == ST_POLL_R2) || (state == ST_VER_RD);
  assign src_idx    = idx;
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);
  assign timeout    = timeout_q;
  assign verify_err = verr_q;

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  a_r4_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> !fl_we && !fl_re);

  a_r5_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL_R1) |=> fl_re && (fl_addr == $past(fl_addr)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(timeout) && $stable(verify_err));

  a_r10_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(bank_q) && $stable(op_q));

  a_r3_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> fl_addr[ADDR_W-1:OFF_W] == bank_q);

endmodule

// File: tb/test_flash_bank_prog.sv
module test_flash_bank_prog;
  localparam int CLK_PERIOD = 10;
  localparam int BW   = 1;
  localparam int BB   = 2048;
  localparam int OW   = $clog2(BB);
  localparam int AW   = BW + OW;
  localparam int GAP  = 1;
  localparam int PLIM = 8;
  localparam int MEMN = BB * (1 << BW);
  localparam int PBUSY = 1;
  localparam int EBUSY = 4;

  logic clk = 1'b0;
  logic rst_n, start, op_prog;
  logic [BW-1:0] bank;
  logic [OW-1:0] src_idx;
  logic [7:0]    src_data;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata, fl_rdata;
  logic fl_we, fl_re, busy, done, timeout, verify_err;

  int cur_pat;
  logic stuck;
  int n_checks = 0;
  int n_fail = 0;
  logic [AW+7:0] exp_q[$];
  int rd_since_we = 0;
  int reads_before_reset = 0;
  int last_we_cyc = -1000;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat_byte(input int p, input int i);
    logic [7:0] v;
    v = (p == 0) ? 8'(i * 7 + 3) : 8'(i * 13 + 5);
    return (p == 2) ? ~v : v;
  endfunction

  function automatic logic [7:0] junk(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  assign src_data = pat_byte(cur_pat, int'(src_idx));

  flash_bank_prog #(.BANK_W(BW), .BANK_BYTES(BB), .GAP_CYCLES(GAP), .POLL_LIMIT(PLIM))
  i_flash_bank_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .bank(bank),
    .src_idx(src_idx), .src_data(src_data), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata), .busy(busy), .done(done),
    .timeout(timeout), .verify_err(verify_err));

  // ---------------- flash model ----------------
  logic [7:0] mem [MEMN];
  int ust;
  int bcnt;
  logic tog;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] = junk(i);
      ust = 0; bcnt = 0; tog = 1'b0;
      fl_rdata <= 8'h00;
    end else begin
      if (fl_we) begin
        int o;
        int b;
        o = int'(fl_addr[OW-1:0]);
        b = int'(fl_addr[AW-1:OW]);
        if (fl_wdata == 8'hF0 && o == 0 && ust != 6) ust = 0;
        else case (ust)
          0: ust = (o == 'h555 && fl_wdata == 8'hAA) ? 1 : 0;
          1: ust = (o == 'h2AA && fl_wdata == 8'h55) ? 2 : 0;
          2: ust = (o == 'h555 && fl_wdata == 8'h80) ? 3 :
                   (o == 'h555 && fl_wdata == 8'hA0) ? 6 : 0;
          3: ust = (o == 'h555 && fl_wdata == 8'hAA) ? 4 : 0;
          4: ust = (o == 'h2AA && fl_wdata == 8'h55) ? 5 : 0;
          5: begin
            if (o == 0 && fl_wdata == 8'h30) begin
              for (int k = 0; k < BB; k++) mem[b * BB + k] = 8'hFF;
              bcnt = EBUSY;
            end
            ust = 0;
          end
          6: begin
            mem[int'(fl_addr)] = mem[int'(fl_addr)] & fl_wdata;
            bcnt = PBUSY;
            ust = 0;
          end
          default: ust = 0;
        endcase
      end
      if (fl_re) begin
        if (stuck || bcnt > 0) begin
          fl_rdata <= {1'b0, tog, 6'b0};
          tog = ~tog;
          if (bcnt > 0) bcnt = bcnt - 1;
        end else begin
          fl_rdata <= mem[int'(fl_addr)];
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes, checks strobe spacing
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (fl_we && fl_re) check(1'b0, "R11", "both strobes", 1, 0);
        if ((fl_we || fl_re) && (cyc - last_we_cyc) <= GAP)
          check(1'b0, "R4", "strobe too soon after write", cyc - last_we_cyc, GAP + 1);
        if (fl_re) rd_since_we++;
        if (fl_we) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R1", "unexpected write", {fl_addr, fl_wdata}, 0);
          end else begin
            logic [AW+7:0] e;
            e = exp_q.pop_front();
            check({fl_addr, fl_wdata} == e, "R2", "write addr/data", {fl_addr, fl_wdata}, e);
          end
          if (fl_wdata == 8'hF0 && fl_addr[OW-1:0] == '0) reads_before_reset = rd_since_we;
          rd_since_we = 0;
          last_we_cyc = cyc;
        end
      end
    end
  end

  task automatic push_w(input int b, input int o, input logic [7:0] d);
    logic [AW-1:0] a;
    a = {BW'(b), OW'(o)};
    exp_q.push_back({a, d});
  endtask

  task automatic push_erase(input int b);
    push_w(b, 'h555, 8'hAA); push_w(b, 'h2AA, 8'h55); push_w(b, 'h555, 8'h80);
    push_w(b, 'h555, 8'hAA); push_w(b, 'h2AA, 8'h55); push_w(b, 0, 8'h30);
    push_w(b, 0, 8'hF0);
  endtask

  task automatic push_prog(input int b, input int p, input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      push_w(b, 'h555, 8'hAA); push_w(b, 'h2AA, 8'h55); push_w(b, 'h555, 8'hA0);
      push_w(b, i, pat_byte(p, i));
    end
    push_w(b, 0, 8'hF0);
  endtask

  task automatic launch(input logic prog, input int b);
    start = 1'b1; op_prog = prog; bank = BW'(b);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", busy, 1);
  endtask

  task automatic wait_done(input logic exp_to, input logic exp_ve);
    int n;
    n = 0;
    while (!done && n < 100000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R9", "done seen", done, 1);
    check(timeout == exp_to, "R6", "timeout flag", timeout, exp_to);
    check(verify_err == exp_ve, "R8", "verify flag", verify_err, exp_ve);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9", "done one cycle", {done, busy}, 0);
    repeat (3) @(negedge clk);
    check(timeout == exp_to && verify_err == exp_ve, "R9", "flags hold",
          {timeout, verify_err}, {exp_to, exp_ve});
    check(exp_q.size() == 0, "R7", "pending expected writes", exp_q.size(), 0);
  endtask

  task automatic bank_diff(input int b, input int kind, output int bad);
    bad = 0;
    for (int i = 0; i < BB; i++) begin
      logic [7:0] e;
      e = (kind < 0) ? 8'hFF : (kind >= 100) ? junk(b * BB + i) : pat_byte(kind, i);
      if (mem[b * BB + i] != e) bad++;
    end
  endtask

  initial begin
    int bad;
    rst_n = 1'b0; start = 1'b0; op_prog = 1'b0; bank = '0; cur_pat = 0; stuck = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check({busy, done, timeout, verify_err, fl_we, fl_re} == 6'b0, "R12", "reset outputs",
          {busy, done, timeout, verify_err, fl_we, fl_re}, 0);

    // R1 erase bank 0, R10 start injected mid-job
    push_erase(0);
    launch(1'b0, 0);
    repeat (3) @(negedge clk);
    start = 1'b1; op_prog = 1'b1; bank = 1'b1;
    @(negedge clk);
    start = 1'b0; op_prog = 1'b0; bank = '0;
    wait_done(1'b0, 1'b0);
    bank_diff(0, -1, bad);
    check(bad == 0, "R1", "bank0 erased bytes wrong", bad, 0);
    bank_diff(1, 100, bad);
    check(bad == 0, "R10", "bank1 untouched", bad, 0);

    // R2 program bank 0 with pattern 0
    cur_pat = 0;
    push_prog(0, 0, BB);
    launch(1'b1, 0);
    wait_done(1'b0, 1'b0);
    bank_diff(0, 0, bad);
    check(bad == 0, "R2", "bank0 program content", bad, 0);

    // R3 erase and program bank 1
    push_erase(1);
    launch(1'b0, 1);
    wait_done(1'b0, 1'b0);
    cur_pat = 1;
    push_prog(1, 1, BB);
    launch(1'b1, 1);
    wait_done(1'b0, 1'b0);
    bank_diff(1, 1, bad);
    check(bad == 0, "R3", "bank1 program content", bad, 0);
    bank_diff(0, 0, bad);
    check(bad == 0, "R3", "bank0 kept", bad, 0);

    // R8 program over unerased bank -> verify error
    cur_pat = 2;
    push_prog(1, 2, BB);
    launch(1'b1, 1);
    wait_done(1'b0, 1'b1);

    // R6 stuck device during erase
    stuck = 1'b1;
    push_erase(0);
    launch(1'b0, 0);
    wait_done(1'b1, 1'b1);
    check(reads_before_reset == 2 * PLIM, "R5", "poll reads before reset",
          reads_before_reset, 2 * PLIM);

    // R6 stuck device during program: only first byte, then reset
    cur_pat = 0;
    push_prog(0, 0, 1);
    launch(1'b1, 0);
    wait_done(1'b1, 1'b1);
    check(reads_before_reset == 2 * PLIM, "R6", "poll reads before reset",
          reads_before_reset, 2 * PLIM);
    stuck = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog expired: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule